// File: doc/BRIEF.md
# Two-Level Interrupt Controller with Sub-Source Grouping

This block gathers up to 32 level-sensitive primary interrupt requests and a second tier of sub-source requests. Each sub-source is tied to one primary parent. A sub-source is latched in its own pending register and filtered by its own mask. While it is live, it holds its parent's pending bit set. Primary pending bits are filtered by a source mask. A per-source mode bit then steers each source either to the normal interrupt output or to the fast interrupt output.

On the normal path, the lowest-numbered eligible source is captured into a one-hot interrupt-pending register. The number of that source is published in an offset register. Software services the interrupt by reading the offset. It then clears the pending state in stages with write-one-to-clear writes: first the sub-source bits, then the source bit, then the interrupt-pending bit. Access is through a simple synchronous word-addressed read/write port whose reads return data one cycle after the request.

Top module: `intc_two_level`

## Requirements
- R1: After reset, the mode register reads 0 and the source mask reads all ones (0xFFFFFFFF). The sub-source mask reads all ones over the sub-source width (0x1FFF for 13 sub-sources). The source-pending, interrupt-pending, sub-source-pending and offset registers read 0. Both `irq` and `fiq` are low.
- R2: A mode bit of 0 sends its source to the normal path and a mode bit of 1 sends it to the fast path. `fiq` is high exactly while some source is pending, unmasked and in mode 1. A source in mode 1 never appears in the interrupt-pending register.
- R3: A source mask bit of 1 blocks that source from both outputs and from the interrupt-pending register, while its source-pending bit still records the request. A mask bit of 0 lets it through.
- R4: A sub-source mask bit of 1 keeps that sub-source from setting its parent's pending bit, while the sub-source-pending bit still records the request.
- R5: Sub-sources map to parents as follows: sub-sources 0 to 2 to source 28, 3 to 5 to source 23, 6 to 8 to source 15, 9 and 10 to source 31, and 11 and 12 to source 6. A pending, unmasked sub-source sets its parent's source-pending bit one cycle later. If the source bit is cleared while such a sub-source is still pending, the source bit is set again.
- R6: Writing to the source-pending, interrupt-pending or sub-source-pending register clears each bit written as 1 and leaves each bit written as 0 unchanged. A bit whose level input is still high stays set.
- R7: While the interrupt-pending register is zero, the lowest-numbered source that is pending, unmasked and in mode 0 is loaded into it as a single set bit on the next clock. A nonzero value is held unchanged, even against lower-numbered arrivals, until it is cleared by a write.
- R8: The offset register holds the bit number of the set bit in the interrupt-pending register, or 0 when that register is zero.
- R9: `irq` is high exactly while the interrupt-pending register is nonzero.
- R10: The word addresses are: 0 source pending, 1 mode, 2 source mask, 3 interrupt pending, 4 offset, 5 sub-source pending, 6 sub-source mask; address 7 reads 0. Read data appears on `rdata` one clock after `rd_en` and holds until the next read.
- R11: Clearing a serviced parent in three steps drops `irq` and leaves both its source-pending bit and its sub-source-pending bits at zero, provided the inputs are low. The steps are the sub-source bits first, then the source bit, then the interrupt-pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | NUM_SRC | Level requests from primary sources |
| sub_in | input | NUM_SUB | Level requests from sub-sources |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Word address of the register |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data, one cycle after `rd_en` |
| irq | output | 1 | Normal interrupt request |
| fiq | output | 1 | Fast interrupt request |

## Verification
The bench builds the block with its default values: 32 sources, 13 sub-sources and the five-group parent map, with a 32-bit data width. These values make the highest index 31 reachable as a sub-source parent. They also let one run exercise a three-member group (parent 28), a fast-path source and a masked source side by side. The bench checks that sub-source-to-parent propagation and the re-set behaviour after an out-of-order clear match the mapping stated in R5.

// File: rtl/intc_pkg.sv
package intc_pkg;

    // Word addresses of the register port.
    typedef enum logic [2:0] {
        A_SRCPND  = 3'd0,
        A_MODE    = 3'd1,
        A_MASK    = 3'd2,
        A_INTPND  = 3'd3,
        A_OFFSET  = 3'd4,
        A_SUBPND  = 3'd5,
        A_SUBMASK = 3'd6
    } reg_sel_e;

endpackage

// File: rtl/intc_pick.sv
// Lowest-index-wins one-hot selector.
module intc_pick #(
    parameter int N = 32
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] onehot
);
    always_comb begin
        onehot = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) onehot = N'(1) << i;
        end
    end
endmodule

// File: rtl/intc_sublayer.sv
// Sub-source pending/mask layer and parent fan-in.
module intc_sublayer #(
    parameter int NUM_SRC = 32,
    parameter int NUM_SUB = 13,
    parameter int unsigned SUB_PARENT [NUM_SUB] = '{28, 28, 28, 23, 23, 23, 15, 15, 15, 31, 31, 6, 6}
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SUB-1:0] sub_in,
    input  logic [NUM_SUB-1:0] clr,
    input  logic               mask_we,
    input  logic [NUM_SUB-1:0] mask_wdata,
    output logic [NUM_SUB-1:0] subpnd,
    output logic [NUM_SUB-1:0] submask,
    output logic [NUM_SRC-1:0] parent_req
);
    typedef struct packed {
        logic [NUM_SUB-1:0] pnd;
        logic [NUM_SUB-1:0] msk;
    } sub_state_t;

    sub_state_t s_d, s_q;
    logic [NUM_SUB-1:0] live;

    always_comb begin
        s_d     = s_q;
        s_d.pnd = (s_q.pnd & ~clr) | sub_in;
        if (mask_we) s_d.msk = mask_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.pnd <= '0;
            s_q.msk <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign live    = s_q.pnd & ~s_q.msk;
    assign subpnd  = s_q.pnd;
    assign submask = s_q.msk;

    generate
        for (genvar p = 0; p < NUM_SRC; p++) begin : g_parent
            logic hit;
            always_comb begin
                hit = 1'b0;
                for (int s = 0; s < NUM_SUB; s++) begin
                    if (SUB_PARENT[s] == 32'(p) && live[s]) hit = 1'b1;
                end
            end
            assign parent_req[p] = hit;
        end
    endgenerate

    AST_SUB_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr & ~sub_in) != '0) |=> ((s_q.pnd & $past(clr & ~sub_in)) == '0)); // R6

    AST_SUB_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_q.pnd & ~s_q.msk) == '0) |-> (parent_req == '0)); // R4
endmodule

// File: rtl/intc_two_level.sv
module intc_two_level
    import intc_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int NUM_SUB = 13,
    parameter int DW      = 32,
    parameter int unsigned SUB_PARENT [NUM_SUB] = '{28, 28, 28, 23, 23, 23, 15, 15, 15, 31, 31, 6, 6}
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic [NUM_SUB-1:0] sub_in,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [2:0]         addr,
    input  logic [DW-1:0]      wdata,
    output logic [DW-1:0]      rdata,
    output logic               irq,
    output logic               fiq
);
    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    typedef struct packed {
        logic [NUM_SRC-1:0] srcpnd;
        logic [NUM_SRC-1:0] mode;
        logic [NUM_SRC-1:0] mask;
        logic [NUM_SRC-1:0] intpnd;
        logic [IDX_W-1:0]   offset;
        logic [DW-1:0]      rdata;
    } top_state_t;

    top_state_t s_d, s_q;

    logic [NUM_SRC-1:0] clr_src, clr_int, cand, winner, parent_req;
    logic [NUM_SUB-1:0] clr_sub, subpnd, submask;
    logic               submask_we;

    assign clr_src    = (wr_en && addr == A_SRCPND) ? wdata[NUM_SRC-1:0] : '0;
    assign clr_int    = (wr_en && addr == A_INTPND) ? wdata[NUM_SRC-1:0] : '0;
    assign clr_sub    = (wr_en && addr == A_SUBPND) ? wdata[NUM_SUB-1:0] : '0;
    assign submask_we = wr_en && addr == A_SUBMASK;

    intc_sublayer #(
        .NUM_SRC    (NUM_SRC),
        .NUM_SUB    (NUM_SUB),
        .SUB_PARENT (SUB_PARENT)
    ) u_sub (
        .clk        (clk),
        .rst_n      (rst_n),
        .sub_in     (sub_in),
        .clr        (clr_sub),
        .mask_we    (submask_we),
        .mask_wdata (wdata[NUM_SUB-1:0]),
        .subpnd     (subpnd),
        .submask    (submask),
        .parent_req (parent_req)
    );

    assign cand = s_q.srcpnd & ~s_q.mask & ~s_q.mode;

    intc_pick #(.N(NUM_SRC)) u_pick (
        .req    (cand),
        .onehot (winner)
    );

    always_comb begin
        s_d        = s_q;
        s_d.srcpnd = (s_q.srcpnd & ~clr_src) | src_in | parent_req;
        if (wr_en && addr == A_MODE) s_d.mode = wdata[NUM_SRC-1:0];
        if (wr_en && addr == A_MASK) s_d.mask = wdata[NUM_SRC-1:0];
        if (s_q.intpnd == '0) s_d.intpnd = winner;
        else                  s_d.intpnd = s_q.intpnd & ~clr_int;
        s_d.offset = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (s_d.intpnd[i]) s_d.offset = IDX_W'(i);
        end
        if (rd_en) begin
            case (addr)
                A_SRCPND:  s_d.rdata = DW'(s_q.srcpnd);
                A_MODE:    s_d.rdata = DW'(s_q.mode);
                A_MASK:    s_d.rdata = DW'(s_q.mask);
                A_INTPND:  s_d.rdata = DW'(s_q.intpnd);
                A_OFFSET:  s_d.rdata = DW'(s_q.offset);
                A_SUBPND:  s_d.rdata = DW'(subpnd);
                A_SUBMASK: s_d.rdata = DW'(submask);
                default:   s_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.srcpnd <= '0;
            s_q.mode   <= '0;
            s_q.mask   <= '1;
            s_q.intpnd <= '0;
            s_q.offset <= '0;
            s_q.rdata  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rdata = s_q.rdata;
    assign irq   = |s_q.intpnd;
    assign fiq   = |(s_q.srcpnd & ~s_q.mask & s_q.mode);

    AST_INTPND_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(s_q.intpnd)); // R7

    AST_INTPND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.intpnd != '0 && !(wr_en && addr == A_INTPND)) |=> $stable(s_q.intpnd)); // R7

    AST_FAST_NOT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.intpnd == '0) |=> ((s_q.intpnd & $past(s_q.mode)) == '0)); // R2

    AST_MASKED_NOT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.intpnd == '0) |=> ((s_q.intpnd & $past(s_q.mask)) == '0)); // R3

    AST_CAND_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.intpnd == '0 && cand != '0) |=> irq); // R9

    AST_OFFSET_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.intpnd != '0) |-> s_q.intpnd[s_q.offset]); // R8
endmodule

// File: tb/intc_two_level_test.sv
`timescale 1ns/1ps
module intc_two_level_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_in = '0;
    logic [12:0] sub_in = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, fiq;

    int checks = 0;
    int fails  = 0;
    bit cmp_en = 1'b0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    intc_two_level uut (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .sub_in(sub_in),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq(irq), .fiq(fiq)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic int parent_of(input int s);
        if (s < 3)  return 28;
        if (s < 6)  return 23;
        if (s < 9)  return 15;
        if (s < 11) return 31;
        return 6;
    endfunction

    // Behavioural reference model.
    logic [31:0] m_src = '0, m_mode = '0, m_mask = '1, m_int = '0, m_off = '0, m_rd = '0;
    logic [12:0] m_sub = '0, m_smask = '1;

    always @(posedge clk) begin : model
        logic [31:0] par, cand, nint;
        int off;
        if (!rst_n) begin
            m_src = '0; m_mode = '0; m_mask = '1; m_int = '0; m_off = '0; m_rd = '0;
            m_sub = '0; m_smask = '1;
        end else begin
            if (rd_en) begin
                case (addr)
                    3'd0: m_rd = m_src;
                    3'd1: m_rd = m_mode;
                    3'd2: m_rd = m_mask;
                    3'd3: m_rd = m_int;
                    3'd4: m_rd = m_off;
                    3'd5: m_rd = {19'd0, m_sub};
                    3'd6: m_rd = {19'd0, m_smask};
                    default: m_rd = '0;
                endcase
            end
            par = '0;
            for (int s = 0; s < 13; s++)
                if (m_sub[s] && !m_smask[s]) par[parent_of(s)] = 1'b1;
            cand = m_src & ~m_mask & ~m_mode;
            nint = '0;
            if (m_int == '0) begin
                for (int i = 0; i < 32; i++)
                    if (cand[i] && nint == '0) nint[i] = 1'b1;
            end else begin
                nint = m_int & ~((wr_en && addr == 3'd3) ? wdata : 32'd0);
            end
            m_src = (m_src & ~((wr_en && addr == 3'd0) ? wdata : 32'd0)) | src_in | par;
            m_sub = (m_sub & ~((wr_en && addr == 3'd5) ? wdata[12:0] : 13'd0)) | sub_in;
            if (wr_en && addr == 3'd1) m_mode = wdata;
            if (wr_en && addr == 3'd2) m_mask = wdata;
            if (wr_en && addr == 3'd6) m_smask = wdata[12:0];
            m_int = nint;
            off = 0;
            for (int i = 0; i < 32; i++) if (nint[i]) off = i;
            m_off = 32'(off);
        end
    end

    always @(negedge clk) begin
        if (cmp_en && !done) begin
            chk("R9 irq vs model", {31'd0, irq}, {31'd0, m_int != '0});
            chk("R2 fiq vs model", {31'd0, fiq}, {31'd0, (m_src & ~m_mask & m_mode) != '0});
            chk("R10 rdata vs model", rdata, m_rd);
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0; wdata = '0;
    endtask

    task automatic do_rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(negedge clk); rd_en = 1'b0;
        v = rdata;
    endtask

    task automatic pulse_src(input logic [31:0] v);
        @(negedge clk); src_in = v;
        @(negedge clk); src_in = '0;
    endtask

    task automatic pulse_sub(input logic [12:0] v);
        @(negedge clk); sub_in = v;
        @(negedge clk); sub_in = '0;
    endtask

    task automatic clean_all();
        do_wr(3'd5, 32'hFFFF_FFFF);
        do_wr(3'd0, 32'hFFFF_FFFF);
        do_wr(3'd3, 32'hFFFF_FFFF);
        idle(2);
    endtask

    initial begin : watchdog
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] v;
        logic [31:0] mk;
        idle(3);
        rst_n = 1'b1;
        cmp_en = 1'b1;
        idle(1);

        // R1 reset values through R10 address map
        chk("R1 irq after reset", {31'd0, irq}, 32'd0);
        chk("R1 fiq after reset", {31'd0, fiq}, 32'd0);
        do_rd(3'd0, v); chk("R1 srcpnd reset", v, 32'd0);
        do_rd(3'd1, v); chk("R1 mode reset", v, 32'd0);
        do_rd(3'd2, v); chk("R1 mask reset", v, 32'hFFFF_FFFF);
        do_rd(3'd3, v); chk("R1 intpnd reset", v, 32'd0);
        do_rd(3'd4, v); chk("R1 offset reset", v, 32'd0);
        do_rd(3'd5, v); chk("R1 subpnd reset", v, 32'd0);
        do_rd(3'd6, v); chk("R10 submask reset at addr 6", v, 32'h0000_1FFF);
        do_rd(3'd7, v); chk("R10 addr 7 reads zero", v, 32'd0);

        // R7/R8/R9 winner selection and hold
        mk = ~((32'd1 << 3) | (32'd1 << 5) | (32'd1 << 9));
        do_wr(3'd2, mk);
        pulse_src(32'd1 << 5);
        idle(2);
        chk("R9 irq with winner", {31'd0, irq}, 32'd1);
        do_rd(3'd4, v); chk("R8 offset of source 5", v, 32'd5);
        pulse_src((32'd1 << 3) | (32'd1 << 9));
        idle(2);
        do_rd(3'd3, v); chk("R7 held against lower index", v, 32'd1 << 5);
        do_wr(3'd0, 32'd1 << 5);
        do_wr(3'd3, 32'd1 << 5);
        do_rd(3'd4, v); chk("R7 lowest pending wins next", v, 32'd3);
        do_rd(3'd3, v); chk("R7 one-hot for source 3", v, 32'd1 << 3);
        clean_all();
        chk("R9 irq low after clean", {31'd0, irq}, 32'd0);

        // R3 masked source, R6 zero-write leaves bits
        pulse_src(32'd1 << 12);
        idle(2);
        do_rd(3'd0, v); chk("R3 masked source recorded", v, 32'd1 << 12);
        chk("R3 masked source no irq", {31'd0, irq}, 32'd0);
        chk("R3 masked source no fiq", {31'd0, fiq}, 32'd0);
        do_wr(3'd0, 32'd0);
        do_rd(3'd0, v); chk("R6 zero write keeps bit", v, 32'd1 << 12);
        @(negedge clk); src_in = 32'd1 << 12;
        do_wr(3'd0, 32'd1 << 12);
        do_rd(3'd0, v); chk("R6 level high re-sets bit", v, 32'd1 << 12);
        @(negedge clk); src_in = '0;
        do_wr(3'd0, 32'd1 << 12);
        do_rd(3'd0, v); chk("R6 write one clears bit", v, 32'd0);

        // R2 fast path
        mk = mk & ~(32'd1 << 20);
        do_wr(3'd2, mk);
        do_wr(3'd1, 32'd1 << 20);
        pulse_src(32'd1 << 20);
        idle(2);
        chk("R2 fiq high for mode 1", {31'd0, fiq}, 32'd1);
        chk("R2 irq low for mode 1", {31'd0, irq}, 32'd0);
        do_rd(3'd3, v); chk("R2 fast source not in intpnd", v, 32'd0);
        clean_all();
        chk("R2 fiq low after clear", {31'd0, fiq}, 32'd0);
        do_wr(3'd1, 32'd0);

        // R4/R5/R11 sub-source layer
        mk = mk & ~(32'd1 << 28);
        do_wr(3'd2, mk);
        do_wr(3'd6, 32'h1FFF & ~32'd2);
        pulse_sub(13'd1);
        idle(3);
        do_rd(3'd0, v); chk("R4 masked sub no parent", v, 32'd0);
        do_rd(3'd5, v); chk("R4 masked sub recorded", v, 32'd1);
        clean_all();
        pulse_sub(13'd2);
        idle(4);
        chk("R5 parent raises irq", {31'd0, irq}, 32'd1);
        do_rd(3'd4, v); chk("R5 offset is parent 28", v, 32'd28);
        do_wr(3'd0, 32'd1 << 28);
        idle(1);
        do_rd(3'd0, v); chk("R5 parent re-set after early clear", v, 32'd1 << 28);
        do_wr(3'd5, 32'd2);
        do_wr(3'd0, 32'd1 << 28);
        do_wr(3'd3, 32'd1 << 28);
        idle(2);
        chk("R11 irq low after staged clear", {31'd0, irq}, 32'd0);
        do_rd(3'd0, v); chk("R11 srcpnd zero", v, 32'd0);
        do_rd(3'd5, v); chk("R11 subpnd zero", v, 32'd0);

        idle(2);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule